// File: doc/BRIEF.md
# Load/Store Address and Part-Word Alignment Unit

This unit sits between the register read stage and the data memory port of a load/store pipeline. For each memory request it forms the effective address from a base register and an offset, produces the base-register update for the auto-increment modes, and steers store data onto the right byte lanes with matching byte enables. The unit remembers the access width, the lane and the extension choice of each load. When the memory answers, it extracts the addressed byte, halfword or word from the returned word and extends it to the full register width.

There are three address forms. The first adds a sign-extended 16-bit constant to the base. The second adds a second register value. The third takes a 21-bit absolute address, zero-extends it and always makes a full-word access. A 2-bit addressing mode chooses whether the access uses the base or the sum, and whether the sum is written back to the base. Requests are registered: memory-side outputs appear one cycle after the request. The load result appears MEM_LAT cycles after that (default 1).

Top module: `lsa_unit`

## Requirements
- R1: While rst_n is low, mem_valid, wb_en and ld_valid are 0.
- R2: Addressing mode (addr_mode[1:0]) chooses the address. Modes 00 and 01 give mem_addr = base_val. Modes 10 and 11 give mem_addr = base_val + offset.
- R3: For req_form other than 10, the base update is enabled exactly when addr_mode[0] = 1, and wb_value = base_val + offset. Mode 01 therefore post-increments and mode 11 pre-increments.
- R4: For req_form 00 and 11, the offset is imm_off sign-extended from 16 bits. For req_form 01, the offset is reg_off.
- R5: size_code 00 selects a halfword, 10 a byte, and 01 or 11 a full word. Lanes are little-endian. A byte sets mem_be bit mem_addr[1:0]. A halfword sets bits 1:0 when mem_addr[1] = 0 and bits 3:2 when mem_addr[1] = 1. A word sets all four bits.
- R6: For a store, mem_we = 1. A byte store sends its low 8 bits of data on every byte lane, a halfword store sends its low 16 bits on both halves, and a word store sends the data unchanged. For a load, mem_we = 0 and mem_wdata = 0.
- R7: A load result takes the byte or halfword from the lane that mem_addr selected, placed in the low bits. When zero_ext = 1 the upper bits are filled with zeros; when zero_ext = 0 they are filled with the sign bit. A word load is returned unchanged.
- R8: In the register-offset form (req_form 01), shift_form = 1 forces a full-word access whatever size_code holds. In the other forms shift_form has no effect.
- R9: In the absolute form (req_form 10), mem_addr is abs_addr zero-extended with its two low bits cleared. The access is full-word and wb_en stays 0.
- R10: The memory outputs and the base update are valid one cycle after a request is sampled. rd_data is sampled MEM_LAT cycles after that, and ld_valid with ld_result are valid on the next cycle.
- R11: A cycle with req_valid = 0 gives mem_valid = 0 and wb_en = 0 on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A memory request is present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_form | input | 2 | 00/11 constant offset, 01 register offset, 10 absolute address |
| addr_mode | input | 2 | Bit 1: address uses the sum; bit 0: write the sum back to the base |
| size_code | input | 2 | 00 halfword, 10 byte, 01/11 full word |
| zero_ext | input | 1 | 1 = zero-extend part-word loads, 0 = sign-extend them |
| shift_form | input | 1 | The register offset comes from a shift operation (forces full word) |
| base_val | input | XLEN | Base register value |
| imm_off | input | IMM_W | Constant offset, sign-extended |
| reg_off | input | XLEN | Register offset value |
| abs_addr | input | ABS_W | Absolute address, zero-extended |
| st_data | input | XLEN | Store source register value |
| rd_data | input | XLEN | Word returned by memory for a load |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | XLEN | Effective address |
| mem_be | output | XLEN/8 | Byte enables, little-endian |
| mem_wdata | output | XLEN | Lane-replicated store data |
| wb_en | output | 1 | Base register update enable |
| wb_value | output | XLEN | New base register value |
| ld_valid | output | 1 | Load result valid |
| ld_result | output | XLEN | Aligned and extended load result |

## Verification
The address, byte enables, store data and base update of a request are due one clock edge after the request is sampled. The load result is due one edge after the cycle in which the memory drives rd_data. Inputs are driven on the falling edge and outputs are compared on the following falling edge. A reference model computes each request's expected memory-side outputs at the moment the request is applied. It derives the expected load result from its own memory image one cycle later, so each comparison falls in the cycle where the result is due. Back-to-back requests are issued to confirm that consecutive results do not overwrite each other in the pipeline.

// File: rtl/lsa_pkg.sv
package lsa_pkg;

   // address form codes carried on req_form
   localparam logic [1:0] FORM_IMM = 2'b00;
   localparam logic [1:0] FORM_REG = 2'b01;
   localparam logic [1:0] FORM_ABS = 2'b10;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_FULL = 2'b10
   } size_e;

   // per-load context carried until the memory answers
   typedef struct packed {
      logic  pend;
      size_e size;
      logic  zext;
   } ld_ctx_t;

   function automatic size_e pick_size(input logic [1:0] code, input logic force_full);
      size_e s;
      if (force_full) begin
         s = SZ_FULL;
      end else begin
         unique case (code)
            2'b00:   s = SZ_HALF;
            2'b10:   s = SZ_BYTE;
            default: s = SZ_FULL;
         endcase
      end
      return s;
   endfunction

endpackage

// File: rtl/lsa_addr_gen.sv
module lsa_addr_gen
   import lsa_pkg::*;
#(
   parameter int XLEN  = 32,
   parameter int IMM_W = 16,
   parameter int ABS_W = 21
) (
   input  logic [1:0]       form,
   input  logic [1:0]       mode,
   input  logic [XLEN-1:0]  base,
   input  logic [IMM_W-1:0] imm,
   input  logic [XLEN-1:0]  roff,
   input  logic [ABS_W-1:0] abs_in,
   output logic [XLEN-1:0]  ea,
   output logic             wb_req,
   output logic [XLEN-1:0]  wb_sum,
   output logic             is_abs
);
   localparam int IMM_PAD = XLEN - IMM_W;
   localparam int ABS_PAD = XLEN - ABS_W;
   localparam logic [XLEN-1:0] WORD_MASK = ~XLEN'(3);

   logic [XLEN-1:0] imm_x;
   logic [XLEN-1:0] offset;
   logic [XLEN-1:0] abs_x;

   // sign extension of the constant; a full-width constant needs no padding
   generate
      if (IMM_PAD > 0) begin : g_imm_pad
         assign imm_x = {{IMM_PAD{imm[IMM_W-1]}}, imm};
      end else begin : g_imm_full
         assign imm_x = imm;
      end
      if (ABS_PAD > 0) begin : g_abs_pad
         assign abs_x = {{ABS_PAD{1'b0}}, abs_in};
      end else begin : g_abs_full
         assign abs_x = abs_in;
      end
   endgenerate

   always_comb begin
      is_abs = (form == FORM_ABS);
      offset = (form == FORM_REG) ? roff : imm_x;
      wb_sum = base + offset;
      if (is_abs) begin
         ea = abs_x & WORD_MASK;
      end else if (mode[1]) begin
         ea = wb_sum;
      end else begin
         ea = base;
      end
      wb_req = mode[0] & ~is_abs;
   end

endmodule

// File: rtl/lsa_store_lane.sv
module lsa_store_lane
   import lsa_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  size_e                size,
   input  logic [$clog2(XLEN/8)-1:0] lane,
   input  logic                 store,
   input  logic [XLEN-1:0]      st_data,
   output logic [XLEN/8-1:0]    be,
   output logic [XLEN-1:0]      wdata
);
   localparam int LANES  = XLEN / 8;
   localparam int LB     = $clog2(LANES);
   localparam int HALVES = XLEN / 16;

   logic [XLEN-1:0] byte_rep;
   logic [XLEN-1:0] half_rep;

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_byte
         assign byte_rep[g*8 +: 8] = st_data[7:0];
      end
      for (genvar h = 0; h < HALVES; h++) begin : g_half
         assign half_rep[h*16 +: 16] = st_data[15:0];
      end
   endgenerate

   always_comb begin
      unique case (size)
         SZ_BYTE: begin
            be    = LANES'(1) << lane;
            wdata = byte_rep;
         end
         SZ_HALF: begin
            be    = LANES'(3) << {lane[LB-1:1], 1'b0};
            wdata = half_rep;
         end
         default: begin
            be    = '1;
            wdata = st_data;
         end
      endcase
      if (!store) begin
         wdata = '0;
      end
   end

endmodule

// File: rtl/lsa_load_align.sv
module lsa_load_align
   import lsa_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  size_e                     size,
   input  logic                      zext,
   input  logic [$clog2(XLEN/8)-1:0] lane,
   input  logic [XLEN-1:0]           rd_data,
   output logic [XLEN-1:0]           result
);
   localparam int LANES = XLEN / 8;
   localparam int LB    = $clog2(LANES);

   logic [7:0]  pick_b;
   logic [15:0] pick_h;
   logic        fill_b;
   logic        fill_h;

   always_comb begin
      pick_b = rd_data[{lane, 3'b000} +: 8];
      pick_h = rd_data[{lane[LB-1:1], 4'b0000} +: 16];
      fill_b = ~zext & pick_b[7];
      fill_h = ~zext & pick_h[15];
      unique case (size)
         SZ_BYTE: result = {{(XLEN-8){fill_b}}, pick_b};
         SZ_HALF: result = {{(XLEN-16){fill_h}}, pick_h};
         default: result = rd_data;
      endcase
   end

endmodule

// File: rtl/lsa_unit.sv
module lsa_unit
   import lsa_pkg::*;
#(
   parameter int XLEN    = 32,
   parameter int IMM_W   = 16,
   parameter int ABS_W   = 21,
   parameter int MEM_LAT = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic               req_store,
   input  logic [1:0]         req_form,
   input  logic [1:0]         addr_mode,
   input  logic [1:0]         size_code,
   input  logic               zero_ext,
   input  logic               shift_form,
   input  logic [XLEN-1:0]    base_val,
   input  logic [IMM_W-1:0]   imm_off,
   input  logic [XLEN-1:0]    reg_off,
   input  logic [ABS_W-1:0]   abs_addr,
   input  logic [XLEN-1:0]    st_data,
   input  logic [XLEN-1:0]    rd_data,
   output logic               mem_valid,
   output logic               mem_we,
   output logic [XLEN-1:0]    mem_addr,
   output logic [XLEN/8-1:0]  mem_be,
   output logic [XLEN-1:0]    mem_wdata,
   output logic               wb_en,
   output logic [XLEN-1:0]    wb_value,
   output logic               ld_valid,
   output logic [XLEN-1:0]    ld_result
);
   localparam int LANES = XLEN / 8;
   localparam int LB    = $clog2(LANES);

   // elaboration-time parameter checks
   generate
      if (XLEN != 32 && XLEN != 64) begin : g_bad_xlen
         $error("lsa_unit: XLEN must be 32 or 64");
      end
      if (IMM_W < 2 || IMM_W > XLEN) begin : g_bad_imm
         $error("lsa_unit: IMM_W out of range");
      end
      if (ABS_W < 3 || ABS_W > XLEN) begin : g_bad_abs
         $error("lsa_unit: ABS_W out of range");
      end
      if (MEM_LAT < 1) begin : g_bad_lat
         $error("lsa_unit: MEM_LAT must be at least 1");
      end
   endgenerate

   // ---------------- request decode ----------------
   logic [XLEN-1:0]  ea_c;
   logic             wb_req_c;
   logic [XLEN-1:0]  wb_sum_c;
   logic             is_abs_c;
   logic             force_full_c;
   size_e            size_c;
   logic [LANES-1:0] be_c;
   logic [XLEN-1:0]  wdata_c;

   lsa_addr_gen #(
      .XLEN (XLEN),
      .IMM_W(IMM_W),
      .ABS_W(ABS_W)
   ) u_addr (
      .form  (req_form),
      .mode  (addr_mode),
      .base  (base_val),
      .imm   (imm_off),
      .roff  (reg_off),
      .abs_in(abs_addr),
      .ea    (ea_c),
      .wb_req(wb_req_c),
      .wb_sum(wb_sum_c),
      .is_abs(is_abs_c)
   );

   always_comb begin
      force_full_c = is_abs_c | ((req_form == FORM_REG) & shift_form);
      size_c       = pick_size(size_code, force_full_c);
   end

   lsa_store_lane #(
      .XLEN(XLEN)
   ) u_store (
      .size   (size_c),
      .lane   (ea_c[LB-1:0]),
      .store  (req_store),
      .st_data(st_data),
      .be     (be_c),
      .wdata  (wdata_c)
   );

   // ---------------- memory-side registers ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_valid <= 1'b0;
         mem_we    <= 1'b0;
         mem_addr  <= '0;
         mem_be    <= '0;
         mem_wdata <= '0;
         wb_en     <= 1'b0;
         wb_value  <= '0;
      end else begin
         mem_valid <= req_valid;
         wb_en     <= req_valid & wb_req_c;
         if (req_valid) begin
            mem_we    <= req_store;
            mem_addr  <= ea_c;
            mem_be    <= be_c;
            mem_wdata <= wdata_c;
            wb_value  <= wb_sum_c;
         end
      end
   end

   // ---------------- load context pipe (MEM_LAT stages) ----------------
   ld_ctx_t          ctx_in;
   ld_ctx_t          ctx_tail;
   logic [LB-1:0]    lane_tail;

   always_comb begin
      ctx_in.pend = req_valid & ~req_store;
      ctx_in.size = size_c;
      ctx_in.zext = zero_ext;
   end

   generate
      for (genvar g = 0; g < MEM_LAT; g++) begin : g_stg
         ld_ctx_t       c;
         logic [LB-1:0] l;
         if (g == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  c <= '0;
                  l <= '0;
               end else begin
                  c <= ctx_in;
                  l <= ea_c[LB-1:0];
               end
            end
         end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  c <= '0;
                  l <= '0;
               end else begin
                  c <= g_stg[g-1].c;
                  l <= g_stg[g-1].l;
               end
            end
         end
      end
   endgenerate

   assign ctx_tail  = g_stg[MEM_LAT-1].c;
   assign lane_tail = g_stg[MEM_LAT-1].l;

   // ---------------- load alignment and result register ----------------
   logic [XLEN-1:0] align_c;

   lsa_load_align #(
      .XLEN(XLEN)
   ) u_load (
      .size   (ctx_tail.size),
      .zext   (ctx_tail.zext),
      .lane   (lane_tail),
      .rd_data(rd_data),
      .result (align_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ld_valid  <= 1'b0;
         ld_result <= '0;
      end else begin
         ld_valid <= ctx_tail.pend;
         if (ctx_tail.pend) begin
            ld_result <= align_c;
         end
      end
   end

endmodule

// File: rtl/lsa_unit_chk.sv
module lsa_unit_chk #(
   parameter int XLEN    = 32,
   parameter int MEM_LAT = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_store,
   input logic [1:0]        req_form,
   input logic [1:0]        addr_mode,
   input logic              shift_form,
   input logic [XLEN-1:0]   base_val,
   input logic              mem_valid,
   input logic              mem_we,
   input logic [XLEN-1:0]   mem_addr,
   input logic [XLEN/8-1:0] mem_be,
   input logic [XLEN-1:0]   mem_wdata,
   input logic              wb_en,
   input logic [XLEN-1:0]   wb_value,
   input logic              ld_valid
);
   localparam int LANES = XLEN / 8;

   // R1: first edge after reset release sees quiet outputs
   a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!mem_valid && !wb_en && !ld_valid));

   // R11: no request gives no memory access and no base update
   a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!mem_valid && !wb_en));

   // R10: request appears on the memory side one cycle later
   a_r10_req_latency: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> (mem_valid && (mem_we == $past(req_store))));

   // R2: post-increment mode addresses with the unmodified base
   a_r2_post_base: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && addr_mode == 2'b01 && req_form != 2'b10) |=> (mem_addr == $past(base_val)));

   // R3: pre-increment mode writes back the address it used
   a_r3_pre_wb: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && addr_mode == 2'b11 && req_form != 2'b10) |=> (wb_en && wb_value == mem_addr));

   // R5: only byte, halfword or full lane patterns
   a_r5_be_shape: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 || $countones(mem_be) == LANES));

   // R6: loads drive no write data
   a_r6_load_wdata: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_we) |-> (mem_wdata == '0));

   // R8: shift-derived register offset forces a full word
   a_r8_shift_full: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_form == 2'b01 && shift_form) |=> (&mem_be));

   // R9: absolute form is aligned, full word, no base update
   a_r9_abs_form: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_form == 2'b10) |=> (!wb_en && mem_addr[1:0] == 2'b00 && (&mem_be)));

   generate
      if (MEM_LAT == 1) begin : g_lat1
         // R10: load result follows the memory access by one cycle
         a_r10_load_latency: assert property (@(posedge clk) disable iff (!rst_n)
            (mem_valid && !mem_we) |=> ld_valid);
      end
   endgenerate

endmodule

bind lsa_unit lsa_unit_chk #(
   .XLEN   (XLEN),
   .MEM_LAT(MEM_LAT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_store (req_store),
   .req_form  (req_form),
   .addr_mode (addr_mode),
   .shift_form(shift_form),
   .base_val  (base_val),
   .mem_valid (mem_valid),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_be    (mem_be),
   .mem_wdata (mem_wdata),
   .wb_en     (wb_en),
   .wb_value  (wb_value),
   .ld_valid  (ld_valid)
);

// File: tb/lsa_unit_test.sv
module lsa_unit_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_store = 1'b0;
   logic [1:0]  req_form = '0;
   logic [1:0]  addr_mode = '0;
   logic [1:0]  size_code = '0;
   logic        zero_ext = 1'b0;
   logic        shift_form = 1'b0;
   logic [31:0] base_val = '0;
   logic [15:0] imm_off = '0;
   logic [31:0] reg_off = '0;
   logic [20:0] abs_addr = '0;
   logic [31:0] st_data = '0;
   logic [31:0] rd_data = '0;
   logic        mem_valid, mem_we, wb_en, ld_valid;
   logic [31:0] mem_addr, mem_wdata, wb_value, ld_result;
   logic [3:0]  mem_be;

   lsa_unit uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
      .req_form(req_form), .addr_mode(addr_mode), .size_code(size_code),
      .zero_ext(zero_ext), .shift_form(shift_form), .base_val(base_val),
      .imm_off(imm_off), .reg_off(reg_off), .abs_addr(abs_addr), .st_data(st_data),
      .rd_data(rd_data), .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_be(mem_be), .mem_wdata(mem_wdata), .wb_en(wb_en), .wb_value(wb_value),
      .ld_valid(ld_valid), .ld_result(ld_result)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0;
   int n_err = 0;
   bit done = 0;

   // reference model state
   logic [31:0] bmem [16];
   bit          e_v = 0;
   bit          e_we;
   bit          e_wb;
   logic [31:0] e_addr, e_wd, e_wbv;
   logic [3:0]  e_be;
   int          e_sz;
   bit          e_zx;
   string       e_tag = "R11";
   bit          l_v = 0;
   logic [31:0] l_res;
   string       l_tag = "R7";

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", what, act, exp);
      end
   endtask

   function automatic logic [31:0] extract(input logic [31:0] w, input int sz,
                                           input logic [1:0] ln, input bit zx);
      logic [31:0] v;
      if (sz == 0) begin
         v = (w >> (8 * ln)) & 32'hFF;
         if (!zx && v[7]) v = v | 32'hFFFF_FF00;
      end else if (sz == 1) begin
         v = (w >> (16 * ln[1])) & 32'hFFFF;
         if (!zx && v[15]) v = v | 32'hFFFF_0000;
      end else begin
         v = w;
      end
      return v;
   endfunction

   // compare the outputs due now, then advance the memory image
   task automatic observe();
      chk("R10 mem_valid", {31'b0, mem_valid}, {31'b0, e_v});
      chk(e_v ? "R3 wb_en" : "R11 wb_en", {31'b0, wb_en}, {31'b0, e_v && e_wb});
      if (e_v) begin
         chk({e_tag, " mem_we"}, {31'b0, mem_we}, {31'b0, e_we});
         chk({e_tag, " mem_addr"}, mem_addr, e_addr);
         chk({e_tag, " mem_be"}, {28'b0, mem_be}, {28'b0, e_be});
         chk({e_tag, " mem_wdata"}, mem_wdata, e_wd);
         if (e_wb) chk({e_tag, " wb_value"}, wb_value, e_wbv);
      end
      chk("R10 ld_valid", {31'b0, ld_valid}, {31'b0, l_v});
      if (l_v) chk({l_tag, " ld_result"}, ld_result, l_res);
      // memory model and load expectation for next cycle
      l_v = 0;
      if (e_v && e_we) begin
         for (int k = 0; k < 4; k++)
            if (e_be[k]) bmem[e_addr[5:2]][8*k +: 8] = e_wd[8*k +: 8];
      end else if (e_v) begin
         l_v   = 1;
         l_tag = e_tag;
         l_res = extract(bmem[e_addr[5:2]], e_sz, e_addr[1:0], e_zx);
      end
      rd_data = bmem[mem_addr[5:2]];
   endtask

   task automatic issue(input string tag, input bit v, input bit st, input logic [1:0] form,
                        input logic [1:0] mode, input logic [1:0] sc, input bit zx, input bit sh,
                        input logic [31:0] b, input logic [15:0] im, input logic [31:0] ro,
                        input logic [20:0] ab, input logic [31:0] sd);
      logic [31:0] off;
      logic [31:0] sum;
      @(negedge clk);
      observe();
      req_valid = v; req_store = st; req_form = form; addr_mode = mode; size_code = sc;
      zero_ext = zx; shift_form = sh; base_val = b; imm_off = im; reg_off = ro;
      abs_addr = ab; st_data = sd;
      e_v = v; e_tag = tag; e_we = st; e_zx = zx;
      off = (form == 2'b01) ? ro : {{16{im[15]}}, im};
      sum = b + off;
      if (form == 2'b10) begin
         e_addr = {11'b0, ab} & 32'hFFFF_FFFC;
         e_wb = 0;
         e_sz = 2;
      end else begin
         e_addr = mode[1] ? sum : b;
         e_wb = mode[0];
         e_sz = (form == 2'b01 && sh) ? 2 : (sc == 2'b10) ? 0 : (sc == 2'b00) ? 1 : 2;
      end
      e_wbv = sum;
      if (e_sz == 0) begin
         e_be = 4'b0001 << e_addr[1:0];
         e_wd = {4{sd[7:0]}};
      end else if (e_sz == 1) begin
         e_be = e_addr[1] ? 4'b1100 : 4'b0011;
         e_wd = {2{sd[15:0]}};
      end else begin
         e_be = 4'b1111;
         e_wd = sd;
      end
      if (!st) e_wd = 32'h0;
   endtask

   // shorthand: constant-offset request
   task automatic rq(input string tag, input bit st, input logic [1:0] mode, input logic [1:0] sc,
                     input bit zx, input logic [31:0] b, input logic [15:0] im, input logic [31:0] sd);
      issue(tag, 1, st, 2'b00, mode, sc, zx, 0, b, im, 32'h0, 21'h0, sd);
   endtask

   task automatic idle();
      issue("R11", 0, 0, 2'b00, 2'b00, 2'b00, 0, 0, 32'h0, 16'h0, 32'h0, 21'h0, 32'h0);
   endtask

   initial begin
      for (int i = 0; i < 16; i++) bmem[i] = 32'h8040_2010 + i * 32'h0713_1F29;
      // R1: reset state
      repeat (2) begin
         @(negedge clk);
         chk("R1 mem_valid", {31'b0, mem_valid}, 32'h0);
         chk("R1 wb_en", {31'b0, wb_en}, 32'h0);
         chk("R1 ld_valid", {31'b0, ld_valid}, 32'h0);
      end
      rst_n = 1'b1;
      idle();
      // R2 / R3: four addressing modes, word loads
      rq("R2", 0, 2'b00, 2'b01, 0, 32'h10, 16'h0008, 0);
      rq("R3", 0, 2'b01, 2'b01, 0, 32'h20, 16'h0004, 0);
      rq("R2", 0, 2'b10, 2'b01, 0, 32'h20, 16'h000C, 0);
      rq("R3", 0, 2'b11, 2'b01, 0, 32'h10, 16'h0010, 0);
      // R4: negative constant and register offset
      rq("R4", 0, 2'b10, 2'b01, 0, 32'h30, 16'hFFF8, 0);
      issue("R4", 1, 0, 2'b01, 2'b11, 2'b01, 0, 0, 32'h04, 16'h7FFF, 32'h14, 21'h0, 0);
      issue("R4", 1, 0, 2'b11, 2'b11, 2'b01, 0, 0, 32'h3C, 16'hFFFC, 32'h0, 21'h0, 0);
      idle();
      // R5 / R6: byte stores on each lane, halfword stores on both halves
      for (int k = 0; k < 4; k++) rq("R5", 1, 2'b10, 2'b10, 0, 32'h30, 16'(k), 32'h1234_5678);
      rq("R6", 1, 2'b00, 2'b00, 0, 32'h34, 0, 32'hCAFE_BEEF);
      rq("R6", 1, 2'b00, 2'b00, 0, 32'h3A, 0, 32'h1357_9ACE);
      rq("R6", 1, 2'b01, 2'b01, 0, 32'h08, 16'h0004, 32'hDEAD_F00D);
      // R7: part-word loads, sign and zero extension, every lane
      for (int k = 0; k < 4; k++) begin
         rq("R7", 0, 2'b10, 2'b10, 0, 32'h34, 16'(k), 0);
         rq("R7", 0, 2'b10, 2'b10, 1, 32'h38, 16'(k), 0);
      end
      rq("R7", 0, 2'b10, 2'b00, 0, 32'h38, 16'h0002, 0);
      rq("R7", 0, 2'b10, 2'b00, 1, 32'h38, 16'h0002, 0);
      rq("R7", 0, 2'b00, 2'b00, 0, 32'h34, 0, 0);
      rq("R7", 0, 2'b00, 2'b01, 1, 32'h08, 0, 0);
      // R5: size code 11 is a full word
      rq("R5", 1, 2'b00, 2'b11, 0, 32'h0C, 0, 32'h0BAD_CAFE);
      rq("R5", 0, 2'b00, 2'b11, 0, 32'h0C, 0, 0);
      // R8: shift form forces full word only in register form
      issue("R8", 1, 1, 2'b01, 2'b10, 2'b10, 0, 1, 32'h21, 16'h0, 32'h02, 21'h0, 32'h7654_3210);
      issue("R8", 1, 0, 2'b01, 2'b10, 2'b00, 0, 1, 32'h20, 16'h0, 32'h03, 21'h0, 0);
      issue("R8", 1, 0, 2'b00, 2'b10, 2'b10, 0, 1, 32'h20, 16'h0003, 32'h0, 21'h0, 0);
      // R9: absolute form with unaligned low bits and an increment mode
      issue("R9", 1, 0, 2'b10, 2'b11, 2'b10, 0, 0, 32'h10, 16'h4, 32'h0, 21'h1F_FFF3, 0);
      issue("R9", 1, 1, 2'b10, 2'b01, 2'b00, 0, 0, 32'h10, 16'h4, 32'h0, 21'h00_0029, 32'h55AA_33CC);
      issue("R9", 1, 0, 2'b10, 2'b00, 2'b10, 0, 0, 32'h0, 16'h0, 32'h0, 21'h00_002A, 0);
      // R11: idle gap then a final request
      idle();
      idle();
      rq("R3", 0, 2'b01, 2'b10, 1, 32'h33, 16'hFFFF, 0);
      idle();
      idle();
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule